// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in front of a DRAM channel and holds a small pool of pending read requests. Every request names a bank, a row, the warp that issued it and a tag giving how many instructions that warp still has to execute. Whenever the bus is free, the block picks one pending request, presents it on the grant port and removes it from the pool. The pick also updates a table with the currently open row of each bank.

A two-bit policy input chooses the ordering rule. Code 0 grants in plain arrival order. Code 1 favours requests that hit their bank's open row and then takes the oldest. Code 2 also favours row hits, but then takes the warp that has received the fewest grants so far. Code 3 also favours row hits, but then takes the request whose warp has the most instructions left. After all of these keys have been applied, any remaining tie goes to the oldest request. A per-warp grant counter feeds the fairness rule.

Top module: `dram_rowhit_sched`

## Requirements
- R1: After reset the pool is empty, req_ready_o is 1, every bank has no open row (so the first grant to any bank reports gnt_hit_o = 0), and all per-warp grant counts are zero.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. At most one is taken per cycle. req_ready_o is 0 while all 16 slots are occupied, and a request offered while it is 0 is dropped.
- R3: gnt_valid_o is 1 in exactly those cycles where bus_free_i is 1 and the pool holds at least one request. The granted request leaves the pool at the next edge, and at most one request is granted per cycle.
- R4: With policy_i = 0 the oldest pending request is granted, whatever its row state.
- R5: With policy_i = 1 a request that hits its bank's open row is granted before any miss, and the oldest request wins among equals.
- R6: With policy_i = 2 row hits win first. Among equals, the request whose warp has the lowest grant count wins, and then the oldest.
- R7: With policy_i = 3 row hits win first. Among equals, the request with the largest remaining-instruction tag wins, and then the oldest.
- R8: Each grant sets the open row of the granted bank to the granted row. gnt_hit_o reports whether the granted request matched the row that was open before the grant. A different row on the same bank is a miss.
- R9: Each warp has a 16-bit saturating grant counter. It counts every grant to that warp under every policy, so counts built up under policies 0 and 1 steer a later pick under policy 2.
- R10: A request can be taken and a different request granted in the same cycle, and both take effect. A newly taken request cannot be granted before the cycle after its acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Ordering rule: 0 arrival, 1 hit+oldest, 2 hit+fair, 3 hit+remaining work |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Pool has a free slot |
| req_bank_i | input | 3 | Request bank |
| req_row_i | input | 14 | Request row |
| req_warp_i | input | 4 | Issuing warp |
| req_rem_i | input | 16 | Instructions left in the issuing warp |
| bus_free_i | input | 1 | A grant may be issued this cycle |
| gnt_valid_o | output | 1 | Grant presented this cycle |
| gnt_bank_o | output | 3 | Granted bank |
| gnt_row_o | output | 14 | Granted row |
| gnt_warp_o | output | 4 | Granted warp |
| gnt_hit_o | output | 1 | Granted request hit the open row |

## Verification
Acceptance of a new request and grant of an older one can occur in the same cycle. The bench provokes this by holding req_valid_i and bus_free_i high together while one request is waiting. It judges the result by three things: the waiting request appears on the grant port in that cycle, the new one appears alone in the next cycle, and nothing is granted after that. A second case offers a request to an empty pool while the bus is free and expects no grant in that same cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    POL_ARRIVAL = 2'd0,
    POL_HIT_OLD = 2'd1,
    POL_HIT_FAIR = 2'd2,
    POL_HIT_WORK = 2'd3
  } policy_e;
endpackage

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DEPTH-1:0]                valid_i,
  input  logic                            alloc_i,
  input  logic [IDX_W-1:0]                alloc_idx_i,
  output logic [DEPTH-1:0][DEPTH-1:0]     older_o
);
  // older_o[r][c] = 1 : entry r arrived before entry c
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    for (genvar c = 0; c < DEPTH; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) older_o[r][c] <= 1'b0;
        else if (alloc_i && alloc_idx_i == IDX_W'(r)) older_o[r][c] <= 1'b0;
        else if (alloc_i && alloc_idx_i == IDX_W'(c)) older_o[r][c] <= valid_i[r];
      end
    end
  end
endmodule

// File: rtl/sched_open_rows.sv
module sched_open_rows #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W = 14,
  parameter int DEPTH = 16,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              upd_i,
  input  logic [BANK_W-1:0]                 upd_bank_i,
  input  logic [ROW_W-1:0]                  upd_row_i,
  input  logic [DEPTH-1:0][BANK_W-1:0]      ent_bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]       ent_row_i,
  output logic [DEPTH-1:0]                  hit_o,
  output logic [NUM_BANKS-1:0]              open_vld_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_vld_o[b] <= 1'b0;
        open_row_o[b] <= '0;
      end else if (upd_i && upd_bank_i == BANK_W'(b)) begin
        open_vld_o[b] <= 1'b1;
        open_row_o[b] <= upd_row_i;
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_hit
    assign hit_o[e] = open_vld_o[ent_bank_i[e]] && (open_row_o[ent_bank_i[e]] == ent_row_i[e]);
  end
endmodule

// File: rtl/sched_warp_credit.sv
module sched_warp_credit #(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W = 16,
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              inc_i,
  input  logic [WARP_W-1:0]                 warp_i,
  output logic [NUM_WARPS-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o[w] <= '0;
      else if (inc_i && warp_i == WARP_W'(w) && cnt_o[w] != '1) cnt_o[w] <= cnt_o[w] + 1'b1;
    end
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int REM_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [1:0]                     policy_i,
  input  logic [DEPTH-1:0]               valid_i,
  input  logic [DEPTH-1:0]               hit_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]    older_i,
  input  logic [DEPTH-1:0][CNT_W-1:0]    cnt_i,
  input  logic [DEPTH-1:0][REM_W-1:0]    rem_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o
);
  import sched_pkg::*;
  policy_e pol;
  logic [DEPTH-1:0] win;

  assign pol = policy_e'(policy_i);

  // entry i wins when it beats every other valid entry j
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      win[i] = valid_i[i];
      for (int j = 0; j < DEPTH; j++) begin
        logic beats;
        if (pol != POL_ARRIVAL && hit_i[i] != hit_i[j]) beats = hit_i[i];
        else if (pol == POL_HIT_FAIR && cnt_i[i] != cnt_i[j]) beats = cnt_i[i] < cnt_i[j];
        else if (pol == POL_HIT_WORK && rem_i[i] != rem_i[j]) beats = rem_i[i] > rem_i[j];
        else beats = older_i[i][j];
        if (j != i && valid_i[j] && !beats) win[i] = 1'b0;
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) if (win[i]) idx_o = idx_o | IDX_W'(i);
  end

  assign any_o = |valid_i;
endmodule

// File: rtl/dram_rowhit_sched.sv
module dram_rowhit_sched #(
  parameter int DEPTH = 16,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W = 14,
  parameter int NUM_WARPS = 16,
  parameter int REM_W = 16,
  parameter int CNT_W = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int WARP_W = $clog2(NUM_WARPS),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [WARP_W-1:0] req_warp_i,
  input  logic [REM_W-1:0]  req_rem_i,
  input  logic              bus_free_i,
  output logic              gnt_valid_o,
  output logic [BANK_W-1:0] gnt_bank_o,
  output logic [ROW_W-1:0]  gnt_row_o,
  output logic [WARP_W-1:0] gnt_warp_o,
  output logic              gnt_hit_o
);
  logic [DEPTH-1:0]                 valid_q;
  logic [DEPTH-1:0][BANK_W-1:0]     bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]      row_q;
  logic [DEPTH-1:0][WARP_W-1:0]     warp_q;
  logic [DEPTH-1:0][REM_W-1:0]      rem_q;
  logic [DEPTH-1:0][DEPTH-1:0]      older;
  logic [DEPTH-1:0]                 hit_vec;
  logic [DEPTH-1:0][CNT_W-1:0]      ent_cnt;
  logic [NUM_WARPS-1:0][CNT_W-1:0]  warp_cnt;
  logic [NUM_BANKS-1:0]             open_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row;
  logic [IDX_W-1:0]                 alloc_idx, win_idx;
  logic                             accept, any_pending;

  assign req_ready_o = ~&valid_q;
  assign accept      = req_valid_i & req_ready_o;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!valid_q[i]) alloc_idx = IDX_W'(i);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign ent_cnt[e] = warp_cnt[warp_q[e]];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        bank_q[e]  <= '0;
        row_q[e]   <= '0;
        warp_q[e]  <= '0;
        rem_q[e]   <= '0;
      end else if (accept && alloc_idx == IDX_W'(e)) begin
        valid_q[e] <= 1'b1;
        bank_q[e]  <= req_bank_i;
        row_q[e]   <= req_row_i;
        warp_q[e]  <= req_warp_i;
        rem_q[e]   <= req_rem_i;
      end else if (gnt_valid_o && win_idx == IDX_W'(e)) begin
        valid_q[e] <= 1'b0;
      end
    end
  end

  sched_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk_i, .rst_ni, .valid_i(valid_q), .alloc_i(accept),
    .alloc_idx_i(alloc_idx), .older_o(older)
  );

  sched_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DEPTH(DEPTH)) u_rows (
    .clk_i, .rst_ni, .upd_i(gnt_valid_o), .upd_bank_i(gnt_bank_o), .upd_row_i(gnt_row_o),
    .ent_bank_i(bank_q), .ent_row_i(row_q), .hit_o(hit_vec),
    .open_vld_o(open_vld), .open_row_o(open_row)
  );

  sched_warp_credit #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_credit (
    .clk_i, .rst_ni, .inc_i(gnt_valid_o), .warp_i(gnt_warp_o), .cnt_o(warp_cnt)
  );

  sched_pick #(.DEPTH(DEPTH), .CNT_W(CNT_W), .REM_W(REM_W)) u_pick (
    .policy_i, .valid_i(valid_q), .hit_i(hit_vec), .older_i(older),
    .cnt_i(ent_cnt), .rem_i(rem_q), .any_o(any_pending), .idx_o(win_idx)
  );

  assign gnt_valid_o = bus_free_i & any_pending;
  assign gnt_bank_o  = bank_q[win_idx];
  assign gnt_row_o   = row_q[win_idx];
  assign gnt_warp_o  = warp_q[win_idx];
  assign gnt_hit_o   = hit_vec[win_idx];
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int DEPTH = 16,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W = 14,
  parameter int NUM_WARPS = 16,
  parameter int CNT_W = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int WARP_W = $clog2(NUM_WARPS)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [1:0]                       policy_i,
  input logic                             req_valid_i,
  input logic                             req_ready_o,
  input logic                             bus_free_i,
  input logic                             gnt_valid_o,
  input logic [BANK_W-1:0]                gnt_bank_o,
  input logic [ROW_W-1:0]                 gnt_row_o,
  input logic [WARP_W-1:0]                gnt_warp_o,
  input logic                             gnt_hit_o,
  input logic [DEPTH-1:0]                 valid_q,
  input logic [DEPTH-1:0]                 hit_vec,
  input logic [NUM_BANKS-1:0]             open_vld,
  input logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row,
  input logic [NUM_WARPS-1:0][CNT_W-1:0]  warp_cnt
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  assert_grant_needs_work_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (bus_free_i && valid_q != '0));
  assert_grant_when_able_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_free_i && valid_q != '0) |-> gnt_valid_o);
  assert_one_leaves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !acc) |=> $countones(valid_q) == $past($countones(valid_q)) - 1);
  assert_one_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !gnt_valid_o) |=> $countones(valid_q) == $past($countones(valid_q)) + 1);
  assert_swap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && gnt_valid_o) |=> $countones(valid_q) == $past($countones(valid_q)));
  assert_full_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(valid_q) == DEPTH) |-> !req_ready_o);
  assert_hit_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && policy_i != 2'd0 && !gnt_hit_o) |-> (hit_vec & valid_q) == '0);
  assert_open_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |=> (open_vld[$past(gnt_bank_o)] && open_row[$past(gnt_bank_o)] == $past(gnt_row_o)));
  assert_credit_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && warp_cnt[gnt_warp_o] != '1) |=>
      warp_cnt[$past(gnt_warp_o)] == $past(warp_cnt[gnt_warp_o]) + 1'b1);
  assert_credit_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && warp_cnt[gnt_warp_o] == '1) |=> warp_cnt[$past(gnt_warp_o)] == '1);
endmodule

bind dram_rowhit_sched sched_checker #(
  .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .bus_free_i(bus_free_i), .gnt_valid_o(gnt_valid_o),
  .gnt_bank_o(gnt_bank_o), .gnt_row_o(gnt_row_o), .gnt_warp_o(gnt_warp_o),
  .gnt_hit_o(gnt_hit_o), .valid_q(valid_q), .hit_vec(hit_vec), .open_vld(open_vld),
  .open_row(open_row), .warp_cnt(warp_cnt)
);

// File: tb/tb_dram_rowhit_sched.sv
module tb_dram_rowhit_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  policy_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_bank_i = '0;
  logic [13:0] req_row_i = '0;
  logic [3:0]  req_warp_i = '0;
  logic [15:0] req_rem_i = '0;
  logic        bus_free_i = 1'b0;
  logic        gnt_valid_o;
  logic [2:0]  gnt_bank_o;
  logic [13:0] gnt_row_o;
  logic [3:0]  gnt_warp_o;
  logic        gnt_hit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dram_rowhit_sched dut (.*);

  typedef struct packed {
    logic [1:0]  pol;
    logic [2:0]  a_bank; logic [13:0] a_row; logic [3:0] a_warp; logic [15:0] a_rem;
    logic [2:0]  b_bank; logic [13:0] b_row; logic [3:0] b_warp; logic [15:0] b_rem;
    logic        pick_b;
  } vec_t;

  // every vector first grants a primer (bank 0, row 5, warp 1), opening row 5 on bank 0
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd1, 14'd9, 4'd3, 16'd10, 3'd0, 14'd5, 4'd4, 16'd20, 1'b0},
    '{2'd1, 3'd1, 14'd9, 4'd3, 16'd10, 3'd0, 14'd5, 4'd4, 16'd20, 1'b1},
    '{2'd1, 3'd1, 14'd9, 4'd3, 16'd10, 3'd2, 14'd7, 4'd4, 16'd20, 1'b0},
    '{2'd1, 3'd0, 14'd5, 4'd3, 16'd10, 3'd0, 14'd5, 4'd4, 16'd20, 1'b0},
    '{2'd2, 3'd1, 14'd9, 4'd1, 16'd10, 3'd2, 14'd7, 4'd2, 16'd20, 1'b1},
    '{2'd2, 3'd0, 14'd5, 4'd1, 16'd10, 3'd2, 14'd7, 4'd2, 16'd20, 1'b0},
    '{2'd3, 3'd1, 14'd9, 4'd3, 16'd10, 3'd2, 14'd7, 4'd4, 16'd50, 1'b1},
    '{2'd3, 3'd0, 14'd5, 4'd3, 16'd10, 3'd2, 14'd7, 4'd4, 16'd50, 1'b0},
    '{2'd3, 3'd1, 14'd9, 4'd3, 16'd30, 3'd2, 14'd7, 4'd4, 16'd30, 1'b0},
    '{2'd2, 3'd1, 14'd9, 4'd2, 16'd10, 3'd2, 14'd7, 4'd3, 16'd20, 1'b0},
    '{2'd1, 3'd1, 14'd9, 4'd3, 16'd10, 3'd0, 14'd6, 4'd4, 16'd20, 1'b0},
    '{2'd0, 3'd0, 14'd5, 4'd3, 16'd10, 3'd1, 14'd9, 4'd4, 16'd20, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_valid_i = 1'b0; bus_free_i = 1'b0; policy_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic enq(input logic [2:0] b, input logic [13:0] r, input logic [3:0] w, input logic [15:0] rem);
    @(negedge clk_i);
    bus_free_i = 1'b0; req_valid_i = 1'b1;
    req_bank_i = b; req_row_i = r; req_warp_i = w; req_rem_i = rem;
  endtask

  // bus free for one cycle; outputs are sampled before the committing edge
  task automatic grant_step(input logic [1:0] pol);
    @(negedge clk_i);
    req_valid_i = 1'b0; bus_free_i = 1'b1; policy_i = pol;
    #2;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; bus_free_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3: watchdog expired, actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state, and no grant from an empty pool (R3)
    do_reset();
    #2;
    chk("R1 ready after reset", req_ready_o, 1);
    grant_step(2'd0);
    chk("R3 empty pool no grant", gnt_valid_o, 0);
    idle();

    // vector table walk: policies R4..R7, open row R8
    for (int v = 0; v < NV; v++) begin
      string tag;
      logic [13:0] er; logic [3:0] ew;
      case (VECS[v].pol)
        2'd0: tag = "R4"; 2'd1: tag = "R5"; 2'd2: tag = "R6"; default: tag = "R7";
      endcase
      er = VECS[v].pick_b ? VECS[v].b_row : VECS[v].a_row;
      ew = VECS[v].pick_b ? VECS[v].b_warp : VECS[v].a_warp;
      do_reset();
      enq(3'd0, 14'd5, 4'd1, 16'd1);
      grant_step(VECS[v].pol);
      chk("R1 first grant after reset misses", gnt_hit_o, 0);
      enq(VECS[v].a_bank, VECS[v].a_row, VECS[v].a_warp, VECS[v].a_rem);
      enq(VECS[v].b_bank, VECS[v].b_row, VECS[v].b_warp, VECS[v].b_rem);
      grant_step(VECS[v].pol);
      chk({tag, " pick row"}, gnt_row_o, er);
      chk({tag, " pick warp"}, gnt_warp_o, ew);
      grant_step(VECS[v].pol);
      chk({tag, " drain second"}, gnt_valid_o, 1);
      grant_step(VECS[v].pol);
      chk({tag, " pool empty"}, gnt_valid_o, 0);
      idle();
    end

    // R8 open row tracking and hit report
    do_reset();
    enq(3'd1, 14'd9, 4'd0, 16'd0); grant_step(2'd1);
    chk("R8 cold bank miss", gnt_hit_o, 0);
    enq(3'd1, 14'd9, 4'd0, 16'd0); grant_step(2'd1);
    chk("R8 same row hit", gnt_hit_o, 1);
    enq(3'd1, 14'd8, 4'd0, 16'd0); grant_step(2'd1);
    chk("R8 other row miss", gnt_hit_o, 0);
    enq(3'd1, 14'd9, 4'd0, 16'd0); grant_step(2'd1);
    chk("R8 row replaced", gnt_hit_o, 0);
    idle();

    // R9 counts from other policies steer the fairness pick
    do_reset();
    enq(3'd3, 14'd40, 4'd1, 16'd0); grant_step(2'd0);
    enq(3'd3, 14'd41, 4'd1, 16'd0); grant_step(2'd0);
    enq(3'd4, 14'd42, 4'd2, 16'd0); grant_step(2'd1);
    enq(3'd1, 14'd30, 4'd1, 16'd0);
    enq(3'd2, 14'd31, 4'd2, 16'd0);
    grant_step(2'd2);
    chk("R9 lower count warp wins", gnt_warp_o, 2);
    chk("R9 lower count row", gnt_row_o, 31);
    idle();

    // R2 fill to capacity, dropped request, arrival-order drain (R4)
    do_reset();
    for (int i = 0; i < 16; i++) enq(3'(i % 8), 14'(100 + i), 4'(i), 16'(i));
    idle();
    #2;
    chk("R2 ready low when full", req_ready_o, 0);
    enq(3'd7, 14'd999, 4'd0, 16'd0);
    idle();
    for (int i = 0; i < 16; i++) begin
      grant_step(2'd0);
      chk("R4 full drain order", gnt_row_o, 14'(100 + i));
    end
    grant_step(2'd0);
    chk("R2 dropped request absent", gnt_valid_o, 0);
    chk("R2 ready after drain", req_ready_o, 1);
    idle();

    // R10 accept and grant together
    do_reset();
    enq(3'd3, 14'd20, 4'd5, 16'd0);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_bank_i = 3'd4; req_row_i = 14'd21; req_warp_i = 4'd6;
    bus_free_i = 1'b1; policy_i = 2'd0;
    #2;
    chk("R10 old entry granted", gnt_row_o, 20);
    chk("R10 ready while granting", req_ready_o, 1);
    grant_step(2'd0);
    chk("R10 new entry next cycle", gnt_row_o, 21);
    grant_step(2'd0);
    chk("R10 nothing left", gnt_valid_o, 0);

    // R10 fresh request not granted in its own cycle
    do_reset();
    @(negedge clk_i);
    req_valid_i = 1'b1; req_bank_i = 3'd2; req_row_i = 14'd55; bus_free_i = 1'b1;
    #2;
    chk("R10 no same-cycle grant", gnt_valid_o, 0);
    grant_step(2'd0);
    chk("R10 granted next cycle", gnt_row_o, 55);
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule